// File: doc/BRIEF.md
# Six-Leg Half-Bridge Gate Sequencer with Non-Overlap Timing

This block turns a per-leg command word into gate enables for six half-bridge legs. Each leg can be in one of three states: both switches off (high impedance), low switch on, or high switch on. Software writes an enable bit and a polarity bit for each leg, and the block drives the high-side and low-side gate enables from them. It never lets both switches of a leg conduct at once.

Whenever a switch turns off, the leg has to wait a programmable number of clock cycles with both switches off before either switch may turn on again. The wait after the high switch opens and the wait after the low switch opens are separate parameters. A fault for one leg clears that leg's command bits, and they stay cleared until software writes the leg again. A global lockout input holds every gate off but keeps the command bits, so the legs return to their programmed state once the lockout is released. Status outputs report the command state that is in force.

Top module: `hbridge_gate_seq`

## Requirements
- R1: After reset every high and low gate enable is 0, and both status vectors are 0.
- R2: A leg whose enable bit is 0 has both gates off, whatever its polarity bit holds.
- R3: A leg with enable 1 and polarity 0 drives only its low gate. A leg with enable 1 and polarity 1 drives only its high gate.
- R4: The high and low gates of the same leg are never 1 in the same cycle.
- R5: When the high gate of a leg turns off and the low gate then turns on, exactly DT_HL_CYC cycles pass between them with both gates off.
- R6: When the low gate of a leg turns off and the high gate then turns on, exactly DT_LH_CYC cycles pass between them with both gates off.
- R7: A gate turns off on the first clock edge at which its leg no longer requests it. A turn-on request that arrives while a non-overlap interval is running takes effect only when that interval ends.
- R8: A pulse on leg_kill[i] clears bit i of both command vectors, and they stay 0 until a later write. If a kill and a write arrive in the same cycle, the kill wins for that leg.
- R9: While lockout is 1, every gate is turned off at the next edge. After lockout falls, each leg goes back to its programmed state, subject to the non-overlap timing.
- R10: st_en reports the stored enable of each leg. st_cfg reports the stored polarity ANDed with that enable. Lockout changes neither of them.
- R11: A command written on clock edge k appears on the status outputs after edge k. If no non-overlap interval is running, it reaches the gates at edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Loads cmd_en and cmd_cfg into the command register |
| cmd_en | input | NUM_LEGS | Per-leg enable; 0 means high impedance |
| cmd_cfg | input | NUM_LEGS | Per-leg polarity; 1 selects the high switch, 0 selects the low switch |
| leg_kill | input | NUM_LEGS | Per-leg fault pulse that clears that leg's command bits |
| lockout | input | 1 | Global lockout; holds all gates off and keeps the command bits |
| hs_on | output | NUM_LEGS | High-side gate enables |
| ls_on | output | NUM_LEGS | Low-side gate enables |
| st_en | output | NUM_LEGS | Stored enable per leg |
| st_cfg | output | NUM_LEGS | Stored polarity per leg, forced to 0 when the enable is 0 |

## Verification
The bench applies several kinds of stimulus:
- Enables at zero with all polarity bits at one. This shows that polarity is ignored while a leg is disabled.
- An alternating polarity pattern and then its inverse. This moves half the legs from high to low and the other half from low to high, so the two non-overlap lengths are measured separately and cannot be confused.
- A polarity flip that is reverted inside the interval. This separates "wait, then honour the latest request" from "restart on the old state".
- A kill on one leg, and a kill that collides with a write. These separate the latched per-leg clear from the non-latching lockout.
- A long lockout and a one-cycle lockout. These show that the stored bits survive and that the legs come back with the correct timing.

// File: rtl/hbgs_pkg.sv
package hbgs_pkg;

   typedef enum logic [1:0] {
      LEG_OFF  = 2'd0,
      LEG_LOW  = 2'd1,
      LEG_HIGH = 2'd2
   } leg_req_e;

   function automatic leg_req_e decode_req(input logic en, input logic cfg);
      if (!en)
         return LEG_OFF;
      return cfg ? LEG_HIGH : LEG_LOW;
   endfunction

endpackage

// File: rtl/hbgs_cmd_reg.sv
module hbgs_cmd_reg #(
   parameter int NUM_LEGS = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [NUM_LEGS-1:0] wr_en,
   input  logic [NUM_LEGS-1:0] wr_cfg,
   input  logic [NUM_LEGS-1:0] kill,
   output logic [NUM_LEGS-1:0] en_q,
   output logic [NUM_LEGS-1:0] cfg_q
);

   logic [NUM_LEGS-1:0] en_d;
   logic [NUM_LEGS-1:0] cfg_d;

   // A fault on a leg beats a write to it in the same cycle.
   always_comb begin
      en_d  = (wr ? wr_en  : en_q)  & ~kill;
      cfg_d = (wr ? wr_cfg : cfg_q) & ~kill;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         cfg_q <= '0;
      end else begin
         en_q  <= en_d;
         cfg_q <= cfg_d;
      end
   end

endmodule

// File: rtl/hbgs_leg.sv
module hbgs_leg
   import hbgs_pkg::*;
#(
   parameter int DT_HL_CYC = 4,
   parameter int DT_LH_CYC = 4,
   parameter int TMR_W     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_en,
   input  logic req_cfg,
   input  logic lockout,
   output logic hs_on,
   output logic ls_on
);

   leg_req_e         want;
   logic [TMR_W-1:0] tmr_q;
   logic [TMR_W-1:0] load_val;
   logic             tmr_idle;
   logic             hs_d;
   logic             ls_d;
   logic             sw_off;

   assign want     = lockout ? LEG_OFF : decode_req(req_en, req_cfg);
   assign tmr_idle = (tmr_q == '0);

   // Reload value: a single constant when both directions match, otherwise
   // picked by which switch is opening.
   generate
      if (DT_HL_CYC == DT_LH_CYC) begin : g_sym
         assign load_val = TMR_W'(DT_HL_CYC - 1);
      end else begin : g_asym
         assign load_val = hs_on ? TMR_W'(DT_HL_CYC - 1) : TMR_W'(DT_LH_CYC - 1);
      end
   endgenerate

   // Turning off is immediate; turning on needs the other side off and the
   // interval expired.
   always_comb begin
      hs_d = hs_on ? (want == LEG_HIGH) : ((want == LEG_HIGH) && !ls_on && tmr_idle);
      ls_d = ls_on ? (want == LEG_LOW)  : ((want == LEG_LOW)  && !hs_on && tmr_idle);
      sw_off = (hs_on && !hs_d) || (ls_on && !ls_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_on <= 1'b0;
         ls_on <= 1'b0;
         tmr_q <= '0;
      end else begin
         hs_on <= hs_d;
         ls_on <= ls_d;
         if (sw_off)
            tmr_q <= load_val;
         else if (!tmr_idle)
            tmr_q <= tmr_q - TMR_W'(1);
      end
   end

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq #(
   parameter int NUM_LEGS  = 6,
   parameter int DT_HL_CYC = 4,
   parameter int DT_LH_CYC = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_wr,
   input  logic [NUM_LEGS-1:0] cmd_en,
   input  logic [NUM_LEGS-1:0] cmd_cfg,
   input  logic [NUM_LEGS-1:0] leg_kill,
   input  logic                lockout,
   output logic [NUM_LEGS-1:0] hs_on,
   output logic [NUM_LEGS-1:0] ls_on,
   output logic [NUM_LEGS-1:0] st_en,
   output logic [NUM_LEGS-1:0] st_cfg
);

   localparam int DT_MAX = (DT_HL_CYC > DT_LH_CYC) ? DT_HL_CYC : DT_LH_CYC;
   localparam int TMR_W  = $clog2(DT_MAX + 1);

   generate
      if (NUM_LEGS < 1) begin : g_bad_legs
         $error("NUM_LEGS must be at least 1");
      end
      if (DT_HL_CYC < 1) begin : g_bad_hl
         $error("DT_HL_CYC must be at least 1");
      end
      if (DT_LH_CYC < 1) begin : g_bad_lh
         $error("DT_LH_CYC must be at least 1");
      end
   endgenerate

   logic [NUM_LEGS-1:0] en_q;
   logic [NUM_LEGS-1:0] cfg_q;

   hbgs_cmd_reg #(.NUM_LEGS(NUM_LEGS)) u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (cmd_wr),
      .wr_en  (cmd_en),
      .wr_cfg (cmd_cfg),
      .kill   (leg_kill),
      .en_q   (en_q),
      .cfg_q  (cfg_q)
   );

   generate
      for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
         hbgs_leg #(
            .DT_HL_CYC (DT_HL_CYC),
            .DT_LH_CYC (DT_LH_CYC),
            .TMR_W     (TMR_W)
         ) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_en  (en_q[g]),
            .req_cfg (cfg_q[g]),
            .lockout (lockout),
            .hs_on   (hs_on[g]),
            .ls_on   (ls_on[g])
         );
      end
   endgenerate

   assign st_en  = en_q;
   assign st_cfg = en_q & cfg_q;

endmodule

// File: rtl/hbgs_checker.sv
module hbgs_checker #(
   parameter int NUM_LEGS  = 6,
   parameter int DT_HL_CYC = 4,
   parameter int DT_LH_CYC = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_wr,
   input logic [NUM_LEGS-1:0] leg_kill,
   input logic                lockout,
   input logic [NUM_LEGS-1:0] hs_on,
   input logic [NUM_LEGS-1:0] ls_on,
   input logic [NUM_LEGS-1:0] st_en
);

   localparam int DT_MAX = (DT_HL_CYC > DT_LH_CYC) ? DT_HL_CYC : DT_LH_CYC;
   localparam int GW     = $clog2(DT_MAX + 2);

   // R4: the two switches of a leg never conduct together
   assert_no_shoot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_on & ls_on) == '0);

   // R9: lockout clears every gate at the following edge
   assert_lockout_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |=> ((hs_on | ls_on) == '0));

   // R10: lockout alone leaves the stored enables unchanged
   assert_lockout_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lockout && !cmd_wr && (leg_kill == '0)) |=> $stable(st_en));

   generate
      for (genvar g = 0; g < NUM_LEGS; g++) begin : g_chk
         logic [GW-1:0] gap_q;
         logic [1:0]    last_q;   // 0 none, 1 high was last on, 2 low was last on

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gap_q  <= '0;
               last_q <= 2'd0;
            end else begin
               if (hs_on[g] || ls_on[g])
                  gap_q <= '0;
               else if (gap_q != GW'(DT_MAX + 1))
                  gap_q <= gap_q + GW'(1);
               if (hs_on[g])
                  last_q <= 2'd1;
               else if (ls_on[g])
                  last_q <= 2'd2;
            end
         end

         // R2: a disabled leg has both gates off one edge later
         assert_disabled_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !st_en[g] |=> (!hs_on[g] && !ls_on[g]));

         // R8: a kill clears the leg's stored enable
         assert_kill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            leg_kill[g] |=> !st_en[g]);

         // R5: high-off to low-on gap
         assert_gap_hl_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ls_on[g]) && last_q == 2'd1) |-> (gap_q >= GW'(DT_HL_CYC)));

         // R6: low-off to high-on gap
         assert_gap_lh_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(hs_on[g]) && last_q == 2'd2) |-> (gap_q >= GW'(DT_LH_CYC)));
      end
   endgenerate

endmodule

bind hbridge_gate_seq hbgs_checker #(
   .NUM_LEGS  (NUM_LEGS),
   .DT_HL_CYC (DT_HL_CYC),
   .DT_LH_CYC (DT_LH_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_wr   (cmd_wr),
   .leg_kill (leg_kill),
   .lockout  (lockout),
   .hs_on    (hs_on),
   .ls_on    (ls_on),
   .st_en    (st_en)
);

// File: tb/hbridge_gate_seq_tb.sv
module hbridge_gate_seq_tb;

   localparam int N  = 6;
   localparam int HL = 4;
   localparam int LH = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_wr = 1'b0;
   logic [N-1:0] cmd_en = '0;
   logic [N-1:0] cmd_cfg = '0;
   logic [N-1:0] leg_kill = '0;
   logic         lockout = 1'b0;
   logic [N-1:0] hs_on, ls_on, st_en, st_cfg;

   always #2 clk = ~clk;   // 250 MHz

   hbridge_gate_seq #(.NUM_LEGS(N), .DT_HL_CYC(HL), .DT_LH_CYC(LH)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_en(cmd_en), .cmd_cfg(cmd_cfg),
      .leg_kill(leg_kill), .lockout(lockout), .hs_on(hs_on), .ls_on(ls_on),
      .st_en(st_en), .st_cfg(st_cfg));

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   bit [N-1:0] m_en, m_cfg, m_hs, m_ls;
   int         m_off_at [N];
   int         m_need [N];
   int         cyc = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_cfg = '0; m_hs = '0; m_ls = '0;
         for (int i = 0; i < N; i++) begin m_off_at[i] = 0; m_need[i] = 0; end
      end else begin
         cyc++;
         for (int i = 0; i < N; i++) begin
            int want;   // 0 off, 1 low, 2 high
            want = lockout ? 0 : (m_en[i] ? (m_cfg[i] ? 2 : 1) : 0);
            if (m_hs[i] && want != 2) begin
               m_hs[i] = 1'b0; m_off_at[i] = cyc; m_need[i] = HL;
            end else if (m_ls[i] && want != 1) begin
               m_ls[i] = 1'b0; m_off_at[i] = cyc; m_need[i] = LH;
            end else if (!m_hs[i] && !m_ls[i] && want != 0 &&
                         (cyc - m_off_at[i]) >= m_need[i]) begin
               if (want == 2) m_hs[i] = 1'b1; else m_ls[i] = 1'b1;
            end
         end
         if (cmd_wr) begin m_en = cmd_en; m_cfg = cmd_cfg; end
         m_en  = m_en & ~leg_kill;
         m_cfg = m_cfg & ~leg_kill;
      end
   end

   // ---------------- per-cycle comparison and gap monitor ----------------
   int hs_fell [N];
   int ls_fell [N];
   int gap_hl [N];
   int gap_lh [N];
   logic [N-1:0] hs_prev = '0, ls_prev = '0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, 32'(hs_on), 32'(m_hs));
         check(cur_req, 32'(ls_on), 32'(m_ls));
         check({cur_req, "/R10"}, 32'(st_en), 32'(m_en));
         check({cur_req, "/R10"}, 32'(st_cfg), 32'(m_en & m_cfg));
         check("R4", 32'(hs_on & ls_on), 32'h0);
         for (int i = 0; i < N; i++) begin
            if (hs_prev[i] && !hs_on[i]) hs_fell[i] = cyc;
            if (ls_prev[i] && !ls_on[i]) ls_fell[i] = cyc;
            if (!ls_prev[i] && ls_on[i]) gap_hl[i] = cyc - hs_fell[i];
            if (!hs_prev[i] && hs_on[i]) gap_lh[i] = cyc - ls_fell[i];
         end
         hs_prev = hs_on;
         ls_prev = ls_on;
      end
   end

   task automatic write_cmd(input logic [N-1:0] en, input logic [N-1:0] cfg);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_en = en; cmd_cfg = cfg;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         hs_fell[i] = 0; ls_fell[i] = 0; gap_hl[i] = -1; gap_lh[i] = -1;
      end
      idle(3);
      // R1: reset state
      check("R1", 32'({hs_on, ls_on, st_en, st_cfg}), 32'h0);
      rst_n = 1'b1;
      idle(2);
      check("R1", 32'({hs_on, ls_on, st_en, st_cfg}), 32'h0);

      // R2: polarity ignored while disabled
      cur_req = "R2";
      write_cmd(6'b000000, 6'b111111);
      idle(3);
      check("R2", 32'(hs_on | ls_on), 32'h0);

      // R3 and R11: mixed polarity from idle, latency of one extra edge
      cur_req = "R3";
      write_cmd(6'b111111, 6'b010101);
      check("R11", 32'(st_en), 32'h3F);
      check("R11", 32'(hs_on | ls_on), 32'h0);
      @(negedge clk);
      check("R3", 32'(hs_on), 32'h15);
      check("R3", 32'(ls_on), 32'h2A);
      idle(3);

      // R5 and R6: invert polarity, both directions at once
      cur_req = "R5/R6";
      write_cmd(6'b111111, 6'b101010);
      idle(12);
      check("R5", 32'(gap_hl[0]), 32'(HL));
      check("R5", 32'(gap_hl[2]), 32'(HL));
      check("R6", 32'(gap_lh[1]), 32'(LH));
      check("R6", 32'(gap_lh[5]), 32'(LH));
      check("R3", 32'(hs_on), 32'h2A);

      // R7: leg0 asks for high then reverts to low during the interval
      cur_req = "R7";
      write_cmd(6'b111111, 6'b101011);
      check("R7", 32'(ls_on[0]), 32'h1);
      @(negedge clk);
      check("R7", 32'(ls_on[0]), 32'h0);      // off on the first edge
      write_cmd(6'b111111, 6'b101010);
      check("R7", 32'(ls_on[0] | hs_on[0]), 32'h0);
      idle(10);
      check("R7", 32'(ls_on[0]), 32'h1);

      // R8: kill leg 2, then a kill colliding with a write on leg 3
      cur_req = "R8";
      @(negedge clk); leg_kill = 6'b000100;
      @(negedge clk); leg_kill = '0;
      check("R8", 32'(st_en[2]), 32'h0);
      idle(3);
      check("R8", 32'(hs_on[2] | ls_on[2]), 32'h0);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_en = 6'b111111; cmd_cfg = 6'b111111; leg_kill = 6'b001000;
      @(negedge clk);
      cmd_wr = 1'b0; leg_kill = '0;
      check("R8", 32'(st_en), 32'h37);
      idle(12);
      check("R8", 32'(st_en[2]), 32'h1);
      write_cmd(6'b111111, 6'b000111);
      idle(10);

      // R9: long lockout keeps the bits, legs come back
      cur_req = "R9";
      @(negedge clk); lockout = 1'b1;
      idle(2);
      check("R9", 32'(hs_on | ls_on), 32'h0);
      check("R10", 32'(st_en), 32'h3F);
      idle(10);
      lockout = 1'b0;
      idle(3);
      check("R9", 32'(hs_on), 32'h07);
      check("R9", 32'(ls_on), 32'h38);

      // R9: one-cycle lockout inside the interval timing
      @(negedge clk); lockout = 1'b1;
      @(negedge clk); lockout = 1'b0;
      idle(12);
      check("R9", 32'(hs_on), 32'h07);
      check("R9", 32'(ls_on), 32'h38);

      // R2 again: disable everything
      cur_req = "R2";
      write_cmd(6'b000000, 6'b101010);
      idle(3);
      check("R2", 32'(hs_on | ls_on), 32'h0);
      check("R10", 32'(st_cfg), 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule